// File: doc/BRIEF.md
# Instrument Status Reporting Tree

This block collects instrument status into a two-level tree of masked summaries. There are three register sets: a standard event set, an operation set and a questionable set. Each set keeps a sticky 8-bit event register and an 8-bit enable mask. Its summary bit is high while any event bit is set together with its enable bit. The operation and questionable sets each take a live 8-bit condition vector. An event bit in those sets latches on a rising edge of its condition bit. The standard event set has no condition vector, and its events arrive as one-cycle pulses.

The three summaries form a live status byte. A request-enable mask over the status byte drives the master summary bit, which sits at bit 6 of the byte and is also brought out on its own pin. Software reaches every register through a plain address / write / read bus, and reads return the raw binary value. Reading an event register clears it, and a clear-all strobe clears all three event registers at once. No part of the data flow is a stream, so every pin is a plain level or strobe, and the bus never stalls.

Top module: `instr_status_tree`

## Requirements
- R1: After reset, all event registers, enable masks and the request-enable mask are zero, and the status byte reads 0.
- R2: Register map (addr -> register): 0 status byte (RO), 1 request-enable mask (RW), 2 standard events (RO), 3 standard enable (RW), 4 operation condition (RO), 5 operation events (RO), 6 operation enable (RW), 7 questionable condition (RO), 8 questionable events (RO), 9 questionable enable (RW). Other addresses read 0. Writes to RO or unmapped addresses change nothing.
- R3: A read strobe at a clock edge loads rd_data with the addressed register's value from before that edge. rd_data holds its value until the next read.
- R4: A condition register read returns the live condition input, with no latching.
- R5: In the operation and questionable sets, an event bit sets on a clock where its condition bit is 1 and was 0 at the previous clock (the previous value is 0 after reset). Standard event bits set on a clock where the pulse input bit is 1.
- R6: A set event bit stays set, and further events on it have no effect, until the bit is cleared.
- R7: Reading an event register clears it after the read. An event arriving on the same clock keeps its bit set.
- R8: clr_all clears all three event registers. It leaves enables, the request-enable mask and the condition readback unchanged, and same-cycle events still set.
- R9: Status byte bit 0 is the standard summary, bit 1 the operation summary and bit 2 the questionable summary. A summary is the OR of (event AND enable). The byte is live and non-latching, and bits 3, 4, 5 and 7 are 0.
- R10: mss_o and status byte bit 6 equal the OR over bits 0..5 of (status byte AND request-enable mask). Request-enable bit 6 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| std_evt_i | input | 8 | Standard event pulses |
| oper_cond_i | input | 8 | Operation condition levels |
| ques_cond_i | input | 8 | Questionable condition levels |
| clr_all | input | 1 | Clear every event register |
| status_byte_o | output | 8 | Live status byte |
| mss_o | output | 1 | Master summary status |

## Verification
The assertions assume that wr_en and rd_en are never high together and that every input is a known value from the first clock after reset. The random stimulus picks exactly one bus operation per cycle, or none, and drives all inputs away from the clock edge. Condition inputs are redrawn each cycle with a bias toward holding their value, so both rising edges and long stable levels occur. This lets the sticky behaviour be observed across repeated edges.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int DW      = 8;
  localparam int AW      = 4;
  localparam int NSET    = 3;
  localparam int MSS_BIT = 6;

  typedef enum logic [AW-1:0] {
    A_STB = 4'd0, A_SRE = 4'd1,
    A_SEV = 4'd2, A_SEN = 4'd3,
    A_OCN = 4'd4, A_OEV = 4'd5, A_OEN = 4'd6,
    A_QCN = 4'd7, A_QEV = 4'd8, A_QEN = 4'd9
  } addr_e;

  // set 0: standard, set 1: operation, set 2: questionable
  function automatic logic [AW-1:0] cond_addr(input int s);
    return (s == 1) ? A_OCN : A_QCN;
  endfunction
  function automatic logic [AW-1:0] evt_addr(input int s);
    return (s == 0) ? A_SEV : (s == 1) ? A_OEV : A_QEV;
  endfunction
  function automatic logic [AW-1:0] en_addr(input int s);
    return (s == 0) ? A_SEN : (s == 1) ? A_OEN : A_QEN;
  endfunction
endpackage

// File: rtl/stat_reg_set.sv
module stat_reg_set #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter bit HAS_COND = 1'b1,
  parameter logic [AW-1:0] EV_ADDR = '0,
  parameter logic [AW-1:0] EN_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          clr_all,
  input  logic [DW-1:0] src_i,
  output logic [DW-1:0] ev_o,
  output logic [DW-1:0] en_o,
  output logic          sum_o
);
  logic [DW-1:0] set_v;
  logic          clr_ev;

  generate
    if (HAS_COND) begin : g_edge
      logic [DW-1:0] cond_q;
      always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= src_i;
      end
      assign set_v = src_i & ~cond_q;
    end else begin : g_pulse
      assign set_v = src_i;
    end
  endgenerate

  assign clr_ev = clr_all | (rd_en && addr == EV_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_o <= '0;
      en_o <= '0;
    end else begin
      ev_o <= (clr_ev ? '0 : ev_o) | set_v;
      if (wr_en && addr == EN_ADDR) en_o <= wr_data;
    end
  end

  assign sum_o = |(ev_o & en_o);

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ev |=> ((ev_o & $past(ev_o)) == $past(ev_o)));
  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_o & $past(set_v)) == $past(set_v)));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> (ev_o == $past(set_v)));
  // R2
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == EN_ADDR) |=> (en_o == $past(wr_data)));
endmodule

// File: rtl/stat_summary.sv
module stat_summary #(
  parameter int DW = 8,
  parameter int NSET = 3,
  parameter int MSS_BIT = 6
) (
  input  logic [NSET-1:0] sum_i,
  input  logic [DW-1:0]   sre_i,
  output logic [DW-1:0]   sb_o,
  output logic            mss_o
);
  logic [DW-1:0] base;
  logic [DW-1:0] mask;

  always_comb begin
    base = '0;
    base[NSET-1:0] = sum_i;
    mask = sre_i;
    mask[MSS_BIT] = 1'b0;
    mss_o = |(base & mask);
    sb_o = base;
    sb_o[MSS_BIT] = mss_o;
  end

  // R9
  unused_bits_chk: assert final (sb_o[DW-1] == 1'b0 && sb_o[5:NSET] == '0);
endmodule

// File: rtl/instr_status_tree.sv
module instr_status_tree
  import stat_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] std_evt_i,
  input  logic [DW-1:0] oper_cond_i,
  input  logic [DW-1:0] ques_cond_i,
  input  logic          clr_all,
  output logic [DW-1:0] status_byte_o,
  output logic          mss_o
);
  logic [DW-1:0]   src [NSET];
  logic [DW-1:0]   ev  [NSET];
  logic [DW-1:0]   en  [NSET];
  logic [NSET-1:0] sum;
  logic [DW-1:0]   sre;
  logic [DW-1:0]   rd_mux;

  assign src[0] = std_evt_i;
  assign src[1] = oper_cond_i;
  assign src[2] = ques_cond_i;

  for (genvar s = 0; s < NSET; s++) begin : g_set
    stat_reg_set #(
      .DW(DW), .AW(AW), .HAS_COND(s != 0),
      .EV_ADDR(evt_addr(s)), .EN_ADDR(en_addr(s))
    ) u_set (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .clr_all(clr_all),
      .src_i(src[s]), .ev_o(ev[s]), .en_o(en[s]), .sum_o(sum[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       sre <= '0;
    else if (wr_en && addr == A_SRE)  sre <= wr_data;
  end

  stat_summary #(.DW(DW), .NSET(NSET), .MSS_BIT(MSS_BIT)) u_sum (
    .sum_i(sum), .sre_i(sre), .sb_o(status_byte_o), .mss_o(mss_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int s = 0; s < NSET; s++) begin
      if (addr == evt_addr(s)) rd_mux = ev[s];
      if (addr == en_addr(s))  rd_mux = en[s];
      if (s != 0 && addr == cond_addr(s)) rd_mux = src[s];
    end
    if (addr == A_STB) rd_mux = status_byte_o;
    if (addr == A_SRE) rd_mux = sre;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R3
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_STB) |=> (rd_data == $past(status_byte_o)));
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R10
  mss_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mss_o |-> ((status_byte_o[5:0] & sre[5:0]) != '0));
endmodule

// File: tb/instr_status_tree_bench.sv
module instr_status_tree_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, clr_all = 1'b0;
  logic [7:0] wr_data = '0, std_evt = '0, oc = '0, qc = '0;
  logic [7:0] rd_data, sb;
  logic mss;
  int n_chk = 0, n_fail = 0;

  logic [7:0] m_ev [3];
  logic [7:0] m_en [3];
  logic [7:0] m_cq [3];
  logic [7:0] m_sre;

  always #5 clk = ~clk;

  instr_status_tree u_instr_status_tree (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .std_evt_i(std_evt), .oper_cond_i(oc),
    .ques_cond_i(qc), .clr_all(clr_all), .status_byte_o(sb), .mss_o(mss)
  );

  function automatic logic [7:0] exp_sb();
    logic [7:0] b = '0;
    for (int s = 0; s < 3; s++) b[s] = |(m_ev[s] & m_en[s]);
    b[6] = |(b[5:0] & m_sre[5:0]);
    return b;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0: return exp_sb();
      4'd1: return m_sre;
      4'd2: return m_ev[0];
      4'd3: return m_en[0];
      4'd4: return oc;
      4'd5: return m_ev[1];
      4'd6: return m_en[1];
      4'd7: return qc;
      4'd8: return m_ev[2];
      4'd9: return m_en[2];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one clock: inputs already placed on std_evt/oc/qc
  task automatic cyc(input logic [3:0] a, input logic we, input logic [7:0] wd,
                     input logic re, input logic ca, input string req);
    logic [7:0] rexp, setv;
    addr = a; wr_en = we; wr_data = wd; rd_en = re; clr_all = ca;
    #1;
    rexp = exp_rd(a);
    for (int s = 0; s < 3; s++) begin
      logic [7:0] src;
      logic clr;
      src  = (s == 0) ? std_evt : (s == 1) ? oc : qc;
      setv = (s == 0) ? src : (src & ~m_cq[s]);
      clr  = ca || (re && a == ((s == 0) ? 4'd2 : (s == 1) ? 4'd5 : 4'd8));
      m_ev[s] = (clr ? 8'h00 : m_ev[s]) | setv;
      m_cq[s] = src;
      if (we && a == ((s == 0) ? 4'd3 : (s == 1) ? 4'd6 : 4'd9)) m_en[s] = wd;
    end
    if (we && a == 4'd1) m_sre = wd;
    @(posedge clk); #2;
    if (re) check(req, rd_data, rexp);
    check("R9", sb, exp_sb());
    check("R10", {7'd0, mss}, {7'd0, exp_sb()[6]});
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; clr_all = 1'b0;
  endtask

  initial begin : watchdog
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < 3; s++) begin m_ev[s] = '0; m_en[s] = '0; m_cq[s] = '0; end
    m_sre = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", sb, 8'h00);
    cyc(4'd3, 0, 0, 1, 0, "R1");
    cyc(4'd1, 0, 0, 1, 0, "R1");

    // R2 writes to RO and unmapped addresses ignored
    cyc(4'd2, 1, 8'hFF, 0, 0, "R2");
    cyc(4'd12, 1, 8'hFF, 0, 0, "R2");
    cyc(4'd2, 0, 0, 1, 0, "R2");
    cyc(4'd12, 0, 0, 1, 0, "R2");

    // R5 rising edge, R4 live condition
    oc = 8'h05;
    cyc(4'd4, 0, 0, 1, 0, "R4");
    cyc(4'd5, 0, 0, 1, 0, "R5");
    // R6 held level causes no new event after read clears
    cyc(4'd5, 0, 0, 1, 0, "R6");
    // R7 same-cycle event during clearing read
    std_evt = 8'h10;
    cyc(4'd2, 0, 0, 1, 0, "R7");
    std_evt = 8'h00;
    cyc(4'd2, 0, 0, 1, 0, "R7");
    // R9/R10 enables and request mask, bit 6 ignored
    std_evt = 8'h01;
    cyc(4'd3, 1, 8'h01, 0, 0, "R9");
    std_evt = 8'h00;
    cyc(4'd1, 1, 8'h40, 0, 0, "R10");
    cyc(4'd0, 0, 0, 1, 0, "R10");
    cyc(4'd1, 1, 8'h41, 0, 0, "R10");
    cyc(4'd0, 0, 0, 1, 0, "R3");
    // R8 clear-all keeps enables and request mask
    qc = 8'h80;
    cyc(4'd0, 0, 0, 0, 1, "R8");
    cyc(4'd8, 0, 0, 1, 0, "R8");
    cyc(4'd3, 0, 0, 1, 0, "R8");
    cyc(4'd1, 0, 0, 1, 0, "R8");
    cyc(4'd7, 0, 0, 1, 0, "R8");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op;
      std_evt = ($urandom_range(3) == 0) ? 8'($urandom()) : 8'h00;
      if ($urandom_range(3) == 0) oc = 8'($urandom());
      if ($urandom_range(3) == 0) qc = 8'($urandom());
      op = $urandom_range(9);
      if (op < 4)      cyc(4'($urandom_range(11)), 0, 0, 1, 0, "R3");
      else if (op < 7) cyc(4'($urandom_range(11)), 1, 8'($urandom()), 0, 0, "R2");
      else if (op < 8) cyc(4'd0, 0, 0, 0, 1, "R8");
      else             cyc(4'd0, 0, 0, 0, 0, "R5");
    end
    for (int a = 0; a < 12; a++) cyc(4'(a), 0, 0, 1, 0, "R2");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule